// File: doc/BRIEF.md
# Late-Write Burst-of-Two SRAM Core

This block models the core of a synchronous static memory with a double-data-rate data path and a fixed burst of two. Each rising clock edge can take one command: a word-pair address and a read/write select. Write data follows one cycle behind its command, one beat on a rising edge and one beat on the next falling edge. Byte enables come with each beat. Read data comes back as two beats, one in each half of a clock period, after a latency of one and a half cycles.

Write data is not placed in the storage array right away. It is held in a single-entry late-write buffer and moves into the array only when the next write's data starts to arrive. Every read compares its address with the buffer and takes each buffered byte whose enable was set from the buffer, so the pending write is always visible. A read that is followed at once by a write to the same address still returns the contents from before that write. Seen from its ports, the memory therefore behaves as if every command took effect in issue order.

Top module: `lwb2_sram`

## Requirements
- R1: A command is taken at a rising edge only when `cmd_valid` is high. A cycle with `cmd_valid` low writes nothing, whatever `wr_data` and `wr_be` carry, and produces no read beat.
- R2: For a write taken at rising edge E, the first data beat and its byte enables are sampled at rising edge E+1 and the second beat at the falling edge that follows E+1.
- R3: `wr_be[l]` enables byte lane l, bits [8l+7:8l], of the beat it accompanies. A lane whose enable is low keeps its earlier value. A write with all enables low changes nothing.
- R4: `cmd_addr` selects a pair of words. The first beat of a burst belongs to word {addr,0} and the second to word {addr,1}.
- R5: For a read taken at rising edge E, the first beat is presented with `rd_valid` high during the low half-period after E+1, and the second beat during the high half-period that begins at E+2.
- R6: The most recent write is held in a one-entry buffer. It is committed to the array, lane by lane, at the rising edge where the next write's first beat is sampled, and it stays readable throughout.
- R7: A read to the address in the buffer returns, for each lane and beat, the buffered byte if that lane was enabled in the buffered write, and the array byte otherwise.
- R8: A read followed in the next cycle by a write to the same address returns the data from before that write.
- R9: Reads on consecutive rising edges produce an unbroken stream of beats, with `rd_valid` staying high.
- R10: `rd_data` is all zeros whenever `rd_valid` is low.
- R11: While `rst_n` is low, `rd_valid` is low, `rd_data` is zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Commands and the first write beat are sampled on the rising edge, the second write beat on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Word-pair address |
| wr_data | input | DATA_W | Write beat data |
| wr_be | input | DATA_W/8 | Byte enables for the current write beat |
| rd_data | output | DATA_W | Read beat data, zero when not valid |
| rd_valid | output | 1 | High during each half-period that carries a read beat |

## Verification
The embedded properties check the timing on every cycle. Each read command must produce a first-beat valid exactly two rising edges later, and each non-read cycle must leave that slot empty. The output data must be zero outside beats, the buffer must hold still on cycles with no write data, and the second-beat enables must be the ones present at the falling edge. Data correctness cannot be seen by any single-cycle property. Forwarding merged per lane, the commit when the next write arrives, read-before-write ordering on one address, lanes left untouched by cleared enables, and commands that must be ignored are all shown only by the bench scenarios, which compare every beat against an in-order memory model.

// File: rtl/lwb2_pkg.sv
`timescale 1ns/1ps
package lwb2_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  typedef struct packed {
    logic vld;
    op_e  op;
  } cmd_kind_t;
endpackage

// File: rtl/lwb2_cmd_stage.sv
`timescale 1ns/1ps
// Command capture: one register stage for the command, one more for the
// read lookup that happens at the following falling edge.
module lwb2_cmd_stage
  import lwb2_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_pend,
  output logic [ADDR_W-1:0] rd_addr
);
  cmd_kind_t         kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_pend_q, rd_pend_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic              rd_go;

  always_comb begin
    kind_d = '0;
    addr_d = addr_q;
    if (cmd_valid) begin
      kind_d.vld = 1'b1;
      kind_d.op  = cmd_rd ? OP_READ : OP_WRITE;
      addr_d     = cmd_addr;
    end
  end

  assign rd_go = kind_q.vld && (kind_q.op == OP_READ);
  assign wr_go = kind_q.vld && (kind_q.op == OP_WRITE);
  assign wr_addr = addr_q;

  always_comb begin
    rd_pend_d = rd_go;
    rd_addr_d = rd_go ? addr_q : rd_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= '0;
      addr_q    <= '0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      kind_q    <= kind_d;
      addr_q    <= addr_d;
      rd_pend_q <= rd_pend_d;
      rd_addr_q <= rd_addr_d;
    end
  end

  assign rd_pend = rd_pend_q;
  assign rd_addr = rd_addr_q;
endmodule

// File: rtl/lwb2_array.sv
`timescale 1ns/1ps
// Storage: one memory per byte lane, two words per command address.
module lwb2_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NLANE  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [NLANE*LANE_W-1:0]  wd0,
  input  logic [NLANE*LANE_W-1:0]  wd1,
  input  logic [NLANE-1:0]         wbe0,
  input  logic [NLANE-1:0]         wbe1,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [NLANE*LANE_W-1:0]  rq0,
  output logic [NLANE*LANE_W-1:0]  rq1
);
  localparam int unsigned WORDS = 2 ** (ADDR_W + 1);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (we && wbe0[l]) mem[{waddr, 1'b0}] <= wd0[l*LANE_W +: LANE_W];
      if (we && wbe1[l]) mem[{waddr, 1'b1}] <= wd1[l*LANE_W +: LANE_W];
    end

    assign rq0[l*LANE_W +: LANE_W] = mem[{raddr, 1'b0}];
    assign rq1[l*LANE_W +: LANE_W] = mem[{raddr, 1'b1}];
  end
endmodule

// File: rtl/lwb2_wbuf.sv
`timescale 1ns/1ps
// One-entry late-write buffer with per-lane read forwarding.
module lwb2_wbuf #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NLANE  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_go,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NLANE*LANE_W-1:0]  wr_data,
  input  logic [NLANE-1:0]         wr_be,
  output logic                     flush_we,
  output logic [ADDR_W-1:0]        flush_addr,
  output logic [NLANE*LANE_W-1:0]  flush_d0,
  output logic [NLANE*LANE_W-1:0]  flush_d1,
  output logic [NLANE-1:0]         flush_be0,
  output logic [NLANE-1:0]         flush_be1,
  input  logic [ADDR_W-1:0]        look_addr,
  input  logic [NLANE*LANE_W-1:0]  arr_q0,
  input  logic [NLANE*LANE_W-1:0]  arr_q1,
  output logic [NLANE*LANE_W-1:0]  look_q0,
  output logic [NLANE*LANE_W-1:0]  look_q1
);
  localparam int unsigned DATA_W = NLANE * LANE_W;

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] d0_q, d0_d;
  logic [NLANE-1:0]  be0_q, be0_d;
  logic              b1_pend_q, b1_pend_d;
  logic [DATA_W-1:0] d1_q, d1_d;
  logic [NLANE-1:0]  be1_q, be1_d;
  logic              hit;

  // rising edge: first beat, address, commit of the previous entry
  always_comb begin
    vld_d     = vld_q | wr_go;
    addr_d    = wr_go ? wr_addr : addr_q;
    d0_d      = wr_go ? wr_data : d0_q;
    be0_d     = wr_go ? wr_be   : be0_q;
    b1_pend_d = wr_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      addr_q    <= '0;
      d0_q      <= '0;
      be0_q     <= '0;
      b1_pend_q <= 1'b0;
    end else begin
      vld_q     <= vld_d;
      addr_q    <= addr_d;
      d0_q      <= d0_d;
      be0_q     <= be0_d;
      b1_pend_q <= b1_pend_d;
    end
  end

  // falling edge: second beat
  always_comb begin
    d1_d  = b1_pend_q ? wr_data : d1_q;
    be1_d = b1_pend_q ? wr_be   : be1_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q  <= '0;
      be1_q <= '0;
    end else begin
      d1_q  <= d1_d;
      be1_q <= be1_d;
    end
  end

  assign flush_we   = wr_go & vld_q;
  assign flush_addr = addr_q;
  assign flush_d0   = d0_q;
  assign flush_d1   = d1_q;
  assign flush_be0  = be0_q;
  assign flush_be1  = be1_q;

  assign hit = vld_q && (addr_q == look_addr);

  for (genvar l = 0; l < NLANE; l++) begin : g_fwd
    assign look_q0[l*LANE_W +: LANE_W] = (hit && be0_q[l]) ? d0_q[l*LANE_W +: LANE_W]
                                                           : arr_q0[l*LANE_W +: LANE_W];
    assign look_q1[l*LANE_W +: LANE_W] = (hit && be1_q[l]) ? d1_q[l*LANE_W +: LANE_W]
                                                           : arr_q1[l*LANE_W +: LANE_W];
  end

  // R6: the entry only moves when new first-beat data arrives
  a_r6_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(addr_q) && $stable(d0_q) && $stable(be0_q)));

  // R2: second-beat enables are those present at the falling edge
  a_r2_beat1_taken: assert property (@(negedge clk) disable iff (!rst_n)
    b1_pend_q |=> (be1_q == $past(wr_be)));
endmodule

// File: rtl/lwb2_rdout.sv
`timescale 1ns/1ps
// Read output: beat 0 registered on the falling edge, beat 1 on the
// following rising edge, selected by clock level.
module lwb2_rdout #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pend,
  input  logic [DATA_W-1:0] m0,
  input  logic [DATA_W-1:0] m1,
  output logic              beat0_vld,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              n_vld_q, n_vld_d;
  logic [DATA_W-1:0] n_dat_q, n_dat_d;
  logic [DATA_W-1:0] hold1_q, hold1_d;
  logic              p_vld_q, p_vld_d;
  logic [DATA_W-1:0] p_dat_q, p_dat_d;

  always_comb begin
    n_vld_d = rd_pend;
    n_dat_d = rd_pend ? m0 : '0;
    hold1_d = rd_pend ? m1 : '0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_vld_q <= 1'b0;
      n_dat_q <= '0;
      hold1_q <= '0;
    end else begin
      n_vld_q <= n_vld_d;
      n_dat_q <= n_dat_d;
      hold1_q <= hold1_d;
    end
  end

  always_comb begin
    p_vld_d = n_vld_q;
    p_dat_d = n_vld_q ? hold1_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld_q <= 1'b0;
      p_dat_q <= '0;
    end else begin
      p_vld_q <= p_vld_d;
      p_dat_q <= p_dat_d;
    end
  end

  assign beat0_vld = n_vld_q;
  assign rd_valid  = clk ? p_vld_q : n_vld_q;
  assign rd_data   = clk ? p_dat_q : n_dat_q;

  // R10: idle low-half slot carries zero data
  a_r10_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    !n_vld_q |-> (n_dat_q == '0));
endmodule

// File: rtl/lwb2_sram.sv
`timescale 1ns/1ps
module lwb2_sram #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic                              cmd_rd,
  input  logic [ADDR_W-1:0]                 cmd_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [DATA_W/lwb2_pkg::LANE_W-1:0] wr_be,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_valid
);
  localparam int unsigned LANE_W = lwb2_pkg::LANE_W;
  localparam int unsigned NLANE  = DATA_W / LANE_W;

  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr;
  logic              flush_we;
  logic [ADDR_W-1:0] flush_addr;
  logic [DATA_W-1:0] flush_d0, flush_d1;
  logic [NLANE-1:0]  flush_be0, flush_be1;
  logic [DATA_W-1:0] arr_q0, arr_q1;
  logic [DATA_W-1:0] look_q0, look_q1;
  logic              beat0_vld;

  lwb2_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_rd   (cmd_rd),
    .cmd_addr (cmd_addr),
    .wr_go    (wr_go),
    .wr_addr  (wr_addr),
    .rd_pend  (rd_pend),
    .rd_addr  (rd_addr)
  );

  lwb2_wbuf #(.ADDR_W(ADDR_W), .NLANE(NLANE), .LANE_W(LANE_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .flush_we  (flush_we),
    .flush_addr(flush_addr),
    .flush_d0  (flush_d0),
    .flush_d1  (flush_d1),
    .flush_be0 (flush_be0),
    .flush_be1 (flush_be1),
    .look_addr (rd_addr),
    .arr_q0    (arr_q0),
    .arr_q1    (arr_q1),
    .look_q0   (look_q0),
    .look_q1   (look_q1)
  );

  lwb2_array #(.ADDR_W(ADDR_W), .NLANE(NLANE), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .we   (flush_we),
    .waddr(flush_addr),
    .wd0  (flush_d0),
    .wd1  (flush_d1),
    .wbe0 (flush_be0),
    .wbe1 (flush_be1),
    .raddr(rd_addr),
    .rq0  (arr_q0),
    .rq1  (arr_q1)
  );

  lwb2_rdout #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pend  (rd_pend),
    .m0       (look_q0),
    .m1       (look_q1),
    .beat0_vld(beat0_vld),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R5: a read taken at edge E fills the low-half slot after E+1
  a_r5_beat0_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_rd) |-> ##2 beat0_vld);

  // R1: no read command, no beat in that slot
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_rd) |-> ##2 !beat0_vld);
endmodule

// File: tb/lwb2_sram_bench.sv
`timescale 1ns/1ps
module lwb2_sram_bench;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_rd;
  logic [3:0]  cmd_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  logic [15:0] rd_data;
  logic        rd_valid;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [15:0] model [32];
  logic [15:0] exp_d [$];
  longint      exp_t [$];
  string       exp_s [$];

  // driver slots: a = command taken at the last rising edge, b = one before
  logic        a_wr, b_wr;
  logic [15:0] a_d0, a_d1, b_d1;
  logic [1:0]  a_be0, a_be1, b_be1;

  lwb2_sram u_lwb2_sram (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_rd   (cmd_rd),
    .cmd_addr (cmd_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // entered at rising edge + 1 ns; returns at the next rising edge + 1 ns
  task automatic issue(input logic v, input logic rd, input logic [3:0] a,
                       input logic [15:0] d0, input logic [1:0] be0,
                       input logic [15:0] d1, input logic [1:0] be1,
                       input string tag);
    longint cap;
    cmd_valid = v;
    cmd_rd    = rd;
    cmd_addr  = a;
    wr_data   = b_wr ? b_d1 : 16'hDEAD;
    wr_be     = b_wr ? b_be1 : 2'b11;
    cap = longint'($time) + 3;
    if (v && rd) begin
      exp_d.push_back(model[{a, 1'b0}]); exp_t.push_back(cap + 7); exp_s.push_back(tag);
      exp_d.push_back(model[{a, 1'b1}]); exp_t.push_back(cap + 9); exp_s.push_back(tag);
    end else if (v) begin
      for (int l = 0; l < 2; l++) begin
        if (be0[l]) model[{a, 1'b0}][l*8 +: 8] = d0[l*8 +: 8];
        if (be1[l]) model[{a, 1'b1}][l*8 +: 8] = d1[l*8 +: 8];
      end
    end
    @(negedge clk); #1;
    wr_data = a_wr ? a_d0 : 16'hBEEF;
    wr_be   = a_wr ? a_be0 : 2'b11;
    b_wr  = a_wr; b_d1 = a_d1; b_be1 = a_be1;
    a_wr  = v && !rd; a_d0 = d0; a_be0 = be0; a_d1 = d1; a_be1 = be1;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d0, input logic [1:0] be0,
                    input logic [15:0] d1, input logic [1:0] be1);
    issue(1'b1, 1'b0, a, d0, be0, d1, be1, "wr");
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    issue(1'b1, 1'b1, a, 16'h0, 2'b00, 16'h0, 2'b00, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 1'b0, 4'h2, 16'h5A5A, 2'b11, 16'hA5A5, 2'b11, "idle");
  endtask

  // monitor: samples 1 ns into every half period
  always begin
    @(clk); #1;
    if (rst_n && !done) begin
      if (rd_valid) begin
        if (exp_d.size() == 0) begin
          check(1'b0, "R1", "unexpected beat", 64'(rd_data), 64'h0);
        end else begin
          check(rd_data == exp_d[0], exp_s[0], "beat data", 64'(rd_data), 64'(exp_d[0]));
          check(longint'($time) == exp_t[0], "R5", "beat time", 64'($time), 64'(exp_t[0]));
          void'(exp_d.pop_front()); void'(exp_t.pop_front()); void'(exp_s.pop_front());
        end
      end else begin
        check(rd_data == 16'h0, "R10", "idle data", 64'(rd_data), 64'h0);
        if (exp_d.size() != 0 && longint'($time) > exp_t[0]) begin
          check(1'b0, "R5", "missing beat at time", 64'($time), 64'(exp_t[0]));
          void'(exp_d.pop_front()); void'(exp_t.pop_front()); void'(exp_s.pop_front());
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog: actual time %0t expected finish before %0t", $time, 800000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_rd = 1'b0; cmd_addr = '0;
    wr_data = '0; wr_be = '0;
    a_wr = 1'b0; b_wr = 1'b0; a_d0 = '0; a_d1 = '0; b_d1 = '0;
    a_be0 = '0; a_be1 = '0; b_be1 = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(rd_valid == 1'b0, "R11", "valid in reset, high half", 64'(rd_valid), 64'h0);
    check(rd_data == 16'h0, "R11", "data in reset, high half", 64'(rd_data), 64'h0);
    @(negedge clk); #1;
    check(rd_valid == 1'b0, "R11", "valid in reset, low half", 64'(rd_valid), 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2 R4: fill every pair with full-width bursts
    for (int a = 0; a < 16; a++)
      wr(4'(a), 16'h1000 + 16'(a * 2), 2'b11, 16'h1001 + 16'(a * 2), 2'b11);
    // R4 R9: back-to-back reads of the whole space
    for (int a = 0; a < 16; a++) rd(4'(a), "R9");
    idle(2);

    // R7 R3: partial write, read straight from the buffer
    wr(4'h3, 16'hAAAA, 2'b01, 16'hBBBB, 2'b10);
    rd(4'h3, "R7");
    idle(1);
    rd(4'h3, "R3");

    // R6: second write commits the first; read both
    wr(4'h5, 16'hC0C0, 2'b11, 16'hC1C1, 2'b10);
    wr(4'h6, 16'hD0D0, 2'b10, 16'hD1D1, 2'b11);
    rd(4'h5, "R6");
    rd(4'h6, "R6");
    idle(3);
    rd(4'h5, "R6");

    // R8: read then immediate write to the same pair
    rd(4'h7, "R8");
    wr(4'h7, 16'hE0E0, 2'b11, 16'hE1E1, 2'b11);
    rd(4'h7, "R8");

    // R3: write with every enable low
    wr(4'h9, 16'hFFFF, 2'b00, 16'hFFFF, 2'b00);
    wr(4'hA, 16'h0A0A, 2'b11, 16'h0B0B, 2'b11);
    rd(4'h9, "R3");

    // R1: idle cycles with data on the bus, then check pair 2 untouched
    idle(3);
    rd(4'h2, "R1");
    idle(2);
    rd(4'hA, "R2");
    rd(4'h3, "R7");
    idle(6);

    check(exp_d.size() == 0, "R5", "beats left undelivered", 64'(exp_d.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule